// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Display Driver

This block lights a dual common-anode seven-segment display from two 4-bit values while using a single hex-to-glyph decoder. A free-running divider on the system clock produces a periodic tick. Each tick flips a digit-select state, and that state does three things in the same cycle: it powers one common anode, it holds the other anode off, and it steers the matching 4-bit value into the shared decoder. The segment pattern on the bus therefore always belongs to the digit that is lit. At a 48 MHz clock and the default terminal count of 200,000, the select flips 240 times a second, so each digit is lit 120 times a second.

Next to the display path, a 5-bit adder drives a row of LEDs with the unsigned sum of the two values, carry included. A held reset turns both anodes off. After reset is released the display stays dark for one full divider period. The left digit then lights first, and the two digits alternate from there.

Top module: `mux_hex_display`

## Requirements
- R1: While `rst_n` is sampled low, and after any clock edge at which it was low, both `an_left_n` and `an_right_n` are 1 (inactive, active-low).
- R2: After reset is released, both anodes stay 1 through the first `DIV_COUNT-1` rising edges with `rst_n` high. After the `DIV_COUNT`-th such edge, `an_left_n` is 0 and `an_right_n` is 1.
- R3: Once lit, the active digit swaps every `DIV_COUNT` clock cycles and holds steady in between. Outside reset, the anodes are never both 0.
- R4: While `an_left_n` is 0, `seg_n` shows the glyph of `digit_l`. While `an_right_n` is 0, it shows the glyph of `digit_r`.
- R5: `seg_n` is active low, with bit 0 = segment a up to bit 6 = segment g. Glyphs for 0..F in the active-high form gfedcba are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. `seg_n` is the bitwise inverse of that value.
- R6: `sum_led` equals the 5-bit unsigned sum `digit_l + digit_r` (0 to 30) at all times, with bit 4 as the most significant bit.
- R7: A reset asserted mid-operation blanks the display. The R2 start-up sequence then repeats from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; blanks the display |
| digit_l | input | 4 | Value for the left digit |
| digit_r | input | 4 | Value for the right digit |
| an_left_n | output | 1 | Left common-anode enable, active low |
| an_right_n | output | 1 | Right common-anode enable, active low |
| seg_n | output | 7 | Shared segment bus, active low, bit 0 = a |
| sum_led | output | 5 | Unsigned sum of the two digits |

## Verification
A corrupted divider count shows at the ports as the wrong spacing between anode swaps, or as the wrong length of the dark period after reset. Either is visible within one `DIV_COUNT` window. A wrong digit-select state or a lost start flag shows up the same cycle: the right digit lights first, both anodes turn on together, or the bus carries the other digit's glyph. The bench sweeps all 256 input pairs through both phases, so any error in the decoder table or the adder appears within a few display periods.

// File: rtl/disp_pkg.sv
// Shared widths and types for the multiplexed hex display.
// Assumes a single clock domain and a 4-bit hex digit.
package disp_pkg;
    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    localparam int SUM_W = NIB_W + 1;

    typedef logic [NIB_W-1:0] nibble_t;
    typedef logic [SEG_W-1:0] glyph_t;
endpackage

// File: rtl/tick_div.sv
// Free-running divider: raises tick for one cycle every DIV_COUNT cycles.
// Assumes DIV_COUNT >= 2; synchronous active-low reset clears the count.
module tick_div #(
    parameter int DIV_COUNT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

    logic [CW-1:0] cnt;

    // terminal-count detect
    assign tick = (cnt == LAST);

    // count up, wrap at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < DIV_COUNT);

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/digit_phase.sv
// Digit-select state: stays dark for one divider period after reset, then
// alternates left/right on each tick. sel = 0 means the left digit is lit.
module digit_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic live,
    output logic sel
);
    // start flag and phase register, both updated on the divider tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
            sel  <= 1'b0;
        end else if (tick) begin
            live <= 1'b1;
            sel  <= live ? ~sel : 1'b0;
        end
    end

    // R2
    dark_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !live);

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sel) && $stable(live));

    // R2
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !live) |=> live && !sel);
endmodule

// File: rtl/hex_glyph.sv
// Combinational hex-to-seven-segment decoder, active-low outputs,
// bit 0 = segment a through bit 6 = segment g.
module hex_glyph
    import disp_pkg::*;
(
    input  nibble_t val,
    output glyph_t  seg_n
);
    glyph_t on;

    // glyph lookup in active-high gfedcba form
    always_comb begin
        case (val)
            4'h0: on = 7'h3F;
            4'h1: on = 7'h06;
            4'h2: on = 7'h5B;
            4'h3: on = 7'h4F;
            4'h4: on = 7'h66;
            4'h5: on = 7'h6D;
            4'h6: on = 7'h7D;
            4'h7: on = 7'h07;
            4'h8: on = 7'h7F;
            4'h9: on = 7'h6F;
            4'hA: on = 7'h77;
            4'hB: on = 7'h7C;
            4'hC: on = 7'h39;
            4'hD: on = 7'h5E;
            4'hE: on = 7'h79;
            default: on = 7'h71;
        endcase
    end

    // invert for common-anode drive
    assign seg_n = ~on;

    // R5
    always_comb begin
        glyph_lit_chk: assert (~seg_n != '0 || $isunknown(val));
    end
endmodule

// File: rtl/mux_hex_display.sv
// Two-digit multiplexed hex display driver. One decoder is shared by both
// digits; the digit-select state drives both the anode enables and the
// input mux. Also outputs the 5-bit sum of the two digits.
// Assumes synchronous active-low reset and DIV_COUNT >= 2.
module mux_hex_display
    import disp_pkg::*;
#(
    parameter int DIV_COUNT = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] digit_l,
    input  logic [NIB_W-1:0] digit_r,
    output logic             an_left_n,
    output logic             an_right_n,
    output logic [SEG_W-1:0] seg_n,
    output logic [SUM_W-1:0] sum_led
);
    logic    tick;
    logic    live;
    logic    sel;
    nibble_t shown;

    tick_div #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    digit_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .live  (live),
        .sel   (sel)
    );

    // route the powered digit's value into the shared decoder
    assign shown = sel ? digit_r : digit_l;

    hex_glyph u_glyph (
        .val   (shown),
        .seg_n (seg_n)
    );

    // anode enables, active low, both off until the first tick
    assign an_left_n  = ~(live & ~sel);
    assign an_right_n = ~(live &  sel);

    // unsigned sum with carry for the LED row
    assign sum_led = SUM_W'(digit_l) + SUM_W'(digit_r);

    // R3
    one_anode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(an_left_n == 1'b0 && an_right_n == 1'b0));

    // R4
    seg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(digit_l) && $stable(digit_r) && $stable(an_left_n)) |-> $stable(seg_n));

    // R6
    sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_led - SUM_W'(digit_r)) == SUM_W'(digit_l));
endmodule

// File: tb/mux_hex_display_test.sv
module mux_hex_display_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit_l = '0;
    logic [3:0] digit_r = '0;
    logic       an_left_n, an_right_n;
    logic [6:0] seg_n;
    logic [4:0] sum_led;

    int total = 0;
    int bad = 0;
    bit done = 0;

    mux_hex_display #(.DIV_COUNT(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .digit_l(digit_l), .digit_r(digit_r),
        .an_left_n(an_left_n), .an_right_n(an_right_n),
        .seg_n(seg_n), .sum_led(sum_led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] exp_glyph(input logic [3:0] v);
        logic [6:0] hi;
        case (v)
            4'h0: hi = 7'h3F; 4'h1: hi = 7'h06; 4'h2: hi = 7'h5B; 4'h3: hi = 7'h4F;
            4'h4: hi = 7'h66; 4'h5: hi = 7'h6D; 4'h6: hi = 7'h7D; 4'h7: hi = 7'h07;
            4'h8: hi = 7'h7F; 4'h9: hi = 7'h6F; 4'hA: hi = 7'h77; 4'hB: hi = 7'h7C;
            4'hC: hi = 7'h39; 4'hD: hi = 7'h5E; 4'hE: hi = 7'h79; default: hi = 7'h71;
        endcase
        return ~hi;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // advance n rising edges, return just after the falling edge
    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // R1 / R2: reset blanking and the dark period after release
    task automatic t_reset_start(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        check({req, " anodes in reset"}, {30'd0, an_left_n, an_right_n}, 32'd3);
        @(negedge clk);
        rst_n = 1'b1;
        cycles(DIV - 1);
        check("R2 dark before first tick", {30'd0, an_left_n, an_right_n}, 32'd3);
        cycles(1);
        check("R2 left lit first", {30'd0, an_left_n, an_right_n}, 32'd1);
    endtask

    // R3: swap every DIV cycles, steady in between
    task automatic t_toggle;
        for (int p = 0; p < 4; p++) begin
            logic [1:0] now;
            now = {an_left_n, an_right_n};
            for (int c = 0; c < DIV - 1; c++) begin
                cycles(1);
                check("R3 hold between ticks", {30'd0, an_left_n, an_right_n}, {30'd0, now});
            end
            cycles(1);
            check("R3 swap on tick", {30'd0, an_left_n, an_right_n}, {30'd0, ~now});
        end
    endtask

    // R4 / R5 / R6: all 256 pairs, both phases
    task automatic t_sweep;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                bit seen_l = 0;
                bit seen_r = 0;
                digit_l = 4'(a);
                digit_r = 4'(b);
                #1;
                check("R6 sum", {27'd0, sum_led}, 32'(a + b));
                for (int c = 0; c < 2 * DIV && !(seen_l && seen_r); c++) begin
                    if (an_left_n == 1'b0 && an_right_n == 1'b0)
                        check("R3 both lit", 32'd1, 32'd0);
                    else if (!an_left_n && !seen_l) begin
                        check("R4 R5 left glyph", {25'd0, seg_n}, {25'd0, exp_glyph(4'(a))});
                        seen_l = 1;
                    end else if (!an_right_n && !seen_r) begin
                        check("R4 R5 right glyph", {25'd0, seg_n}, {25'd0, exp_glyph(4'(b))});
                        seen_r = 1;
                    end
                    if (!(seen_l && seen_r)) cycles(1);
                end
                check("R4 both phases seen", {30'd0, seen_l, seen_r}, 32'd3);
            end
        end
    endtask

    // R7: reset in the middle of the right phase
    task automatic t_mid_reset;
        while (an_right_n) cycles(1);
        cycles(2);
        t_reset_start("R7");
    endtask

    initial begin
        t_reset_start("R1");
        t_toggle;
        t_sweep;
        t_mid_reset;
        t_toggle;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule